// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between the point where instructions become ready and the execution units of an out-of-order core. Each ready instruction is pushed once, carrying its sequence number, an operation class, a thread number and a flag that marks it as squashed. The block keeps one queue per operation class, sorted by sequence number, and grants up to `ISSUE_W` instructions per cycle. The oldest waiting instruction of the whole block goes first, whichever class it belongs to.

A per-class vector from the execution side tells the selector whether that class has a free unit this cycle. A class with no free unit is passed over, and its stall counter advances. An instruction that was squashed after becoming ready is dropped when it reaches the head of its queue. It is never granted and needs no unit, but it uses one selection step of the cycle. A running count of such drops is kept.

The push side is a valid/ready stream. `push_ready` depends only on the class carried in `push_cls`: it is low while that class's queue is full. An instruction is taken on a rising edge where both `push_valid` and `push_ready` are high. A producer facing low ready must hold its data, or it may switch to a different class. Grants carry no back-pressure: the execution side takes every valid slot in the cycle it appears.

Top module: `issue_sel`

## Requirements
- R1: After reset, every grant slot is invalid, `squash_cnt` and every `busy_cnt` field are zero, and all queues are empty, so `push_ready` is high for every class.
- R2: A push is accepted only when `push_valid` and `push_ready` are both high. `push_ready` is low exactly when class `push_cls` holds `DEPTH` entries. A refused push leaves no trace and is never granted.
- R3: Within one class, instructions leave in increasing order of sequence number, whatever order they were pushed in. A push older than the current head becomes the new head.
- R4: Each cycle runs `ISSUE_W` selection steps. Each step takes the oldest eligible head across all classes, with ties going to the lowest class index. Slot k of the grant output holds the result of step k, so valid slots carry increasing sequence numbers.
- R5: A non-squashed head is eligible only if `fu_free[c]` is 1 and class c has not yet been granted in the same cycle. This gives at most one grant per class per cycle.
- R6: A squashed head is eligible whatever the state of `fu_free`. It is removed without a grant, its step's slot stays invalid, and `squash_cnt` increases by one.
- R7: Field c of `busy_cnt` increases by one in each cycle where `fu_free[c]` is 0 and class c still has a non-squashed head after that cycle's steps. It is unchanged in any other cycle.
- R8: An instruction accepted at edge N is first eligible for selection at edge N+1. Grants are registered, so a selection made at an edge appears on the outputs just after that edge. Slot k uses bits `[k*SEQ_W +: SEQ_W]` of `gnt_seq`, `[k*CLS_W +: CLS_W]` of `gnt_cls` and `[k*TID_W +: TID_W]` of `gnt_tid`. Class c's counter is `busy_cnt[c*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A ready instruction is offered |
| push_ready | output | 1 | The queue of class `push_cls` has room |
| push_seq | input | SEQ_W | Sequence number (unique, smaller is older) |
| push_cls | input | CLS_W | Operation class |
| push_squash | input | 1 | Instruction has been squashed |
| push_tid | input | TID_W | Thread number |
| fu_free | input | NCLS | Bit c: class c has a free unit this cycle |
| gnt_valid | output | ISSUE_W | Bit k: slot k holds a grant |
| gnt_seq | output | ISSUE_W*SEQ_W | Sequence number per slot |
| gnt_cls | output | ISSUE_W*CLS_W | Class per slot |
| gnt_tid | output | ISSUE_W*TID_W | Thread per slot |
| busy_cnt | output | NCLS*CNT_W | Per-class count of stalled cycles |
| squash_cnt | output | CNT_W | Count of squashed heads dropped |

## Verification
Each push reaches the queue at its accepting edge. Its grant, its drop count or its stall count are all updated at the next edge, together, because selection and the output registers share that single edge. The bench drives inputs on falling edges. It loads queues while `fu_free` is held low, then opens the units at a falling edge and reads the grant slots at each following falling edge, one selection per read. Stall counts are checked as differences over a known number of edges, starting from an edge where the class queue was still empty. This keeps the count free of edges spent loading.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;
  // Outcome of one selection step inside a cycle.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_GRANT = 2'd1,
    ACT_DROP  = 2'd2
  } step_act_e;
endpackage

// File: rtl/iss_class_queue.sv
// One class queue kept sorted by sequence number, oldest at index 0.
// Entry layout: [SEQ_W-1:0] sequence, then thread, squash flag at the MSB.
module iss_class_queue #(
  parameter int DEPTH = 4,
  parameter int EW    = 11,
  parameter int SEQ_W = 8,
  parameter int POP_W = 2,
  parameter int QCW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_en,
  input  logic [EW-1:0]              ins_ent,
  input  logic [POP_W-1:0]           pop_n,
  output logic [DEPTH-1:0][EW-1:0]   ents,
  output logic [QCW-1:0]             cnt
);
  logic [DEPTH-1:0][EW-1:0] ents_q, sh, nxt;
  logic [QCW-1:0]           cnt_q, nxt_cnt;

  always_comb begin
    int left;
    int pos;
    // remove the entries taken this cycle from the front
    for (int i = 0; i < DEPTH; i++) begin
      sh[i] = '0;
      if (i + int'(pop_n) < DEPTH) sh[i] = ents_q[i + int'(pop_n)];
    end
    left = int'(cnt_q) - int'(pop_n);
    // insertion point: number of survivors older than the new entry
    pos = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < left && sh[i][SEQ_W-1:0] < ins_ent[SEQ_W-1:0]) pos = pos + 1;
    end
    nxt     = sh;
    nxt_cnt = QCW'(left);
    if (ins_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == pos) nxt[i] = ins_ent;
        else if (i > pos && i > 0) nxt[i] = sh[i-1];
      end
      nxt_cnt = QCW'(left + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents_q <= '0;
      cnt_q  <= '0;
    end else begin
      ents_q <= nxt;
      cnt_q  <= nxt_cnt;
    end
  end

  assign ents = ents_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/iss_oldest_pick.sv
// Finds the eligible candidate with the smallest sequence number.
module iss_oldest_pick #(
  parameter int N     = 4,
  parameter int SEQ_W = 8,
  parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            elig,
  input  logic [N-1:0][SEQ_W-1:0] seqs,
  output logic                    any,
  output logic [IW-1:0]           idx
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || seqs[i] < best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = seqs[i];
      end
    end
  end
endmodule

// File: rtl/iss_ev_counter.sv
// Wrapping event counter advanced by a small amount per cycle.
module iss_ev_counter #(
  parameter int W  = 16,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q + W'(inc);
  end
endmodule

// File: rtl/issue_sel.sv
module issue_sel
  import issue_sel_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int DEPTH   = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 2,
  parameter int CNT_W   = 16,
  parameter int CLS_W   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_valid,
  output logic                      push_ready,
  input  logic [SEQ_W-1:0]          push_seq,
  input  logic [CLS_W-1:0]          push_cls,
  input  logic                      push_squash,
  input  logic [TID_W-1:0]          push_tid,
  input  logic [NCLS-1:0]           fu_free,
  output logic [ISSUE_W-1:0]        gnt_valid,
  output logic [ISSUE_W*SEQ_W-1:0]  gnt_seq,
  output logic [ISSUE_W*CLS_W-1:0]  gnt_cls,
  output logic [ISSUE_W*TID_W-1:0]  gnt_tid,
  output logic [NCLS*CNT_W-1:0]     busy_cnt,
  output logic [CNT_W-1:0]          squash_cnt
);
  localparam int PW  = $clog2(ISSUE_W + 1);
  localparam int EW  = SEQ_W + TID_W + 1;
  localparam int QCW = $clog2(DEPTH + 1);
  localparam int SQ  = EW - 1;

  logic [DEPTH-1:0][EW-1:0] q_ents [NCLS];
  logic [QCW-1:0]           q_cnt  [NCLS];
  logic [ISSUE_W-1:0]       drop_v;
  logic [EW-1:0]            push_ent;

  assign push_ent = {push_squash, push_tid, push_seq};

  always_comb begin
    push_ready = 1'b0;
    for (int c = 0; c < NCLS; c++) begin
      if (push_cls == CLS_W'(c)) push_ready = (q_cnt[c] != QCW'(DEPTH));
    end
  end

  // Selection steps, chained: each sees the removals made by the ones before.
  for (genvar k = 0; k < ISSUE_W; k++) begin : g_step
    logic [NCLS-1:0][PW-1:0]    pc_in, pc_out;
    logic [NCLS-1:0]            us_in, us_out;
    logic [NCLS-1:0]            hv, elig;
    logic [NCLS-1:0][EW-1:0]    hent;
    logic [NCLS-1:0][SEQ_W-1:0] hseq;
    logic                       any;
    logic [CLS_W-1:0]           win;
    logic [EW-1:0]              went;
    step_act_e                  act;
    logic                       v_q;
    logic [SEQ_W-1:0]           s_q;
    logic [CLS_W-1:0]           c_q;
    logic [TID_W-1:0]           t_q;

    if (k == 0) begin : g_first
      assign pc_in = '0;
      assign us_in = '0;
    end else begin : g_chain
      assign pc_in = g_step[k-1].pc_out;
      assign us_in = g_step[k-1].us_out;
    end

    always_comb begin
      for (int c = 0; c < NCLS; c++) begin
        hv[c]   = 1'b0;
        hent[c] = '0;
        for (int j = 0; j < DEPTH; j++) begin
          if (j == int'(pc_in[c]) && j < int'(q_cnt[c])) begin
            hv[c]   = 1'b1;
            hent[c] = q_ents[c][j];
          end
        end
        hseq[c] = hent[c][SEQ_W-1:0];
        elig[c] = hv[c] && (hent[c][SQ] || (fu_free[c] && !us_in[c]));
      end
    end

    iss_oldest_pick #(.N(NCLS), .SEQ_W(SEQ_W), .IW(CLS_W)) u_pick (
      .elig (elig),
      .seqs (hseq),
      .any  (any),
      .idx  (win)
    );

    always_comb begin
      went   = hent[win];
      pc_out = pc_in;
      us_out = us_in;
      act    = ACT_NONE;
      if (any) begin
        pc_out[win] = pc_in[win] + 1'b1;
        if (went[SQ]) begin
          act = ACT_DROP;
        end else begin
          act         = ACT_GRANT;
          us_out[win] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= '0;
        c_q <= '0;
        t_q <= '0;
      end else begin
        v_q <= (act == ACT_GRANT);
        s_q <= went[SEQ_W-1:0];
        c_q <= win;
        t_q <= went[SEQ_W +: TID_W];
      end
    end

    assign drop_v[k]                   = (act == ACT_DROP);
    assign gnt_valid[k]                = v_q;
    assign gnt_seq[k*SEQ_W +: SEQ_W]   = s_q;
    assign gnt_cls[k*CLS_W +: CLS_W]   = c_q;
    assign gnt_tid[k*TID_W +: TID_W]   = t_q;
  end

  // Per-class queue, removal count and stall accounting.
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [PW-1:0] fin_pc;
    logic          fin_v, fin_sq, ins_en, busy_inc;

    assign fin_pc = g_step[ISSUE_W-1].pc_out[c];
    assign ins_en = push_valid && push_ready && (push_cls == CLS_W'(c));

    always_comb begin
      fin_v  = 1'b0;
      fin_sq = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(fin_pc) && j < int'(q_cnt[c])) begin
          fin_v  = 1'b1;
          fin_sq = q_ents[c][j][SQ];
        end
      end
    end

    assign busy_inc = fin_v && !fin_sq && !fu_free[c];

    iss_class_queue #(.DEPTH(DEPTH), .EW(EW), .SEQ_W(SEQ_W), .POP_W(PW), .QCW(QCW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .ins_en  (ins_en),
      .ins_ent (push_ent),
      .pop_n   (fin_pc),
      .ents    (q_ents[c]),
      .cnt     (q_cnt[c])
    );

    iss_ev_counter #(.W(CNT_W), .IW(1)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (busy_inc),
      .q     (busy_cnt[c*CNT_W +: CNT_W])
    );
  end

  iss_ev_counter #(.W(CNT_W), .IW(PW)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (PW'($countones(drop_v))),
    .q     (squash_cnt)
  );
endmodule

// File: rtl/issue_sel_chk.sv
module issue_sel_chk #(
  parameter int NCLS    = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int CNT_W   = 16,
  parameter int CLS_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCLS-1:0]          fu_free,
  input logic [ISSUE_W-1:0]       gnt_valid,
  input logic [ISSUE_W*SEQ_W-1:0] gnt_seq,
  input logic [ISSUE_W*CLS_W-1:0] gnt_cls,
  input logic [CNT_W-1:0]         squash_cnt
);
  logic [NCLS-1:0] fu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fu_q <= '0;
    else        fu_q <= fu_free;
  end

  // R1: outputs leave reset clean
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gnt_valid == '0 && squash_cnt == '0));

  // R6: drops and grants together never exceed the steps of a cycle
  p_step_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(CNT_W'(squash_cnt - $past(squash_cnt))) + $countones(gnt_valid)) <= ISSUE_W);

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    // R5: a grant only goes to a class whose unit was free at selection
    p_unit_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[k] |-> fu_q[gnt_cls[k*CLS_W +: CLS_W]]);

    for (genvar m = k + 1; m < ISSUE_W; m++) begin : g_pair
      // R4: later slots hold younger instructions
      p_slot_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[k] && gnt_valid[m]) |->
          (gnt_seq[k*SEQ_W +: SEQ_W] < gnt_seq[m*SEQ_W +: SEQ_W]));
      // R5: one grant per class per cycle
      p_one_per_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[k] && gnt_valid[m]) |->
          (gnt_cls[k*CLS_W +: CLS_W] != gnt_cls[m*CLS_W +: CLS_W]));
    end
  end
endmodule

bind issue_sel issue_sel_chk #(
  .NCLS(NCLS), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .CLS_W(CLS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fu_free    (fu_free),
  .gnt_valid  (gnt_valid),
  .gnt_seq    (gnt_seq),
  .gnt_cls    (gnt_cls),
  .squash_cnt (squash_cnt)
);

// File: tb/issue_sel_test.sv
`timescale 1ns/1ps
module issue_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid;
  logic        push_ready;
  logic [7:0]  push_seq;
  logic [1:0]  push_cls;
  logic        push_squash;
  logic [1:0]  push_tid;
  logic [3:0]  fu_free;
  logic [1:0]  gnt_valid;
  logic [15:0] gnt_seq;
  logic [3:0]  gnt_cls;
  logic [3:0]  gnt_tid;
  logic [63:0] busy_cnt;
  logic [15:0] squash_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  issue_sel uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_seq(push_seq), .push_cls(push_cls), .push_squash(push_squash),
    .push_tid(push_tid), .fu_free(fu_free), .gnt_valid(gnt_valid),
    .gnt_seq(gnt_seq), .gnt_cls(gnt_cls), .gnt_tid(gnt_tid),
    .busy_cnt(busy_cnt), .squash_cnt(squash_cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int busy_of(int c);
    return int'(busy_cnt[c*16 +: 16]);
  endfunction

  task automatic slot(string req, int k, int v, int s, int c);
    chk(req, $sformatf("slot%0d valid", k), int'(gnt_valid[k]), v);
    if (v != 0) begin
      chk(req, $sformatf("slot%0d seq", k), int'(gnt_seq[k*8 +: 8]), s);
      chk(req, $sformatf("slot%0d cls", k), int'(gnt_cls[k*2 +: 2]), c);
    end
  endtask

  // Offer one instruction for one edge; returns at the falling edge after it.
  task automatic push(int s, int c, int sq, int t);
    @(negedge clk);
    push_valid  = 1'b1;
    push_seq    = 8'(s);
    push_cls    = 2'(c);
    push_squash = 1'(sq);
    push_tid    = 2'(t);
    @(negedge clk);
    push_valid  = 1'b0;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "gnt_valid", int'(gnt_valid), 0);
    chk("R1", "squash_cnt", int'(squash_cnt), 0);
    chk("R1", "busy_cnt", int'(busy_cnt != 64'd0), 0);
    for (int c = 0; c < 4; c++) begin
      push_cls = 2'(c);
      #1;
      chk("R1", $sformatf("push_ready cls%0d", c), int'(push_ready), 1);
    end
  endtask

  task automatic t_cross_age;
    fu_free = 4'b0000;
    push(30, 0, 0, 1);
    push(10, 1, 0, 2);
    push(20, 2, 0, 3);
    push(40, 3, 0, 0);
    fu_free = 4'b1111;
    step();
    slot("R4", 0, 1, 10, 1);
    slot("R4", 1, 1, 20, 2);
    chk("R8", "slot0 tid", int'(gnt_tid[1:0]), 2);
    chk("R8", "slot1 tid", int'(gnt_tid[3:2]), 3);
    step();
    slot("R4", 0, 1, 30, 0);
    slot("R4", 1, 1, 40, 3);
    step();
    chk("R4", "drained", int'(gnt_valid), 0);
  endtask

  task automatic t_in_class;
    fu_free = 4'b0000;
    push(50, 2, 0, 0);
    push(45, 2, 0, 0);
    push(60, 2, 0, 0);
    fu_free = 4'b0100;
    step();
    slot("R3", 0, 1, 45, 2);
    slot("R5", 1, 0, 0, 0);
    step();
    slot("R3", 0, 1, 50, 2);
    slot("R5", 1, 0, 0, 0);
    step();
    slot("R3", 0, 1, 60, 2);
    step();
    chk("R3", "drained", int'(gnt_valid), 0);
  endtask

  task automatic t_squash_step;
    int sc;
    fu_free = 4'b0000;
    push(90, 0, 0, 0);
    push(91, 0, 1, 0);
    push(92, 1, 0, 0);
    sc = int'(squash_cnt);
    fu_free = 4'b1111;
    step();
    slot("R6", 0, 1, 90, 0);
    slot("R6", 1, 0, 0, 0);
    chk("R6", "squash_cnt", int'(squash_cnt), sc + 1);
    step();
    slot("R6", 0, 1, 92, 1);
    slot("R6", 1, 0, 0, 0);
    step();
  endtask

  task automatic t_squash_busy;
    int sc;
    int b3;
    fu_free = 4'b0000;
    sc = int'(squash_cnt);
    b3 = busy_of(3);
    push(100, 3, 1, 0);
    step();
    chk("R6", "squash_cnt busy", int'(squash_cnt), sc + 1);
    chk("R6", "no grant", int'(gnt_valid), 0);
    chk("R7", "busy3 after drop", busy_of(3), b3);
  endtask

  task automatic t_busy;
    int b0;
    int b1;
    fu_free = 4'b0000;
    b1 = busy_of(1);
    push(110, 2, 0, 0);
    b0 = busy_of(2);
    repeat (3) step();
    chk("R7", "busy2 delta", busy_of(2) - b0, 3);
    chk("R7", "busy1 empty", busy_of(1), b1);
    fu_free = 4'b0100;
    step();
    slot("R7", 0, 1, 110, 2);
    chk("R7", "busy2 when free", busy_of(2) - b0, 3);
    fu_free = 4'b0000;
    step();
    chk("R7", "busy2 when empty", busy_of(2) - b0, 3);
  endtask

  task automatic t_full;
    fu_free = 4'b0000;
    push(130, 1, 0, 0);
    push(131, 1, 0, 0);
    push(132, 1, 0, 0);
    push(133, 1, 0, 0);
    push_cls = 2'd1;
    #1;
    chk("R2", "ready full", int'(push_ready), 0);
    push_cls = 2'd0;
    #1;
    chk("R2", "ready other", int'(push_ready), 1);
    push(129, 1, 0, 0);
    fu_free = 4'b0010;
    for (int i = 0; i < 4; i++) begin
      step();
      slot("R2", 0, 1, 130 + i, 1);
    end
    step();
    chk("R2", "refused absent", int'(gnt_valid), 0);
    fu_free = 4'b0000;
  endtask

  task automatic t_latency;
    fu_free = 4'b0001;
    push(200, 0, 0, 0);
    chk("R8", "not same edge", int'(gnt_valid), 0);
    step();
    slot("R8", 0, 1, 200, 0);
    step();
    chk("R8", "after", int'(gnt_valid), 0);
    fu_free = 4'b0000;
  endtask

  initial begin
    rst_n = 1'b0;
    push_valid = 1'b0;
    push_seq = '0;
    push_cls = '0;
    push_squash = 1'b0;
    push_tid = '0;
    fu_free = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cross_age();
    t_in_class();
    t_squash_step();
    t_squash_busy();
    t_busy();
    t_full();
    t_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule